// File: doc/BRIEF.md
# SCSI DMA Channel Control and Status Registers

This block holds the software-visible control state for the DMA channel and the interrupt line of a SCSI controller core. A word-addressed bus port reaches four 32-bit registers inside a 16-byte window: a control/status word, a DMA address pointer and two general-purpose words. The block does not move any data. It keeps the channel's direction, enable and status bits. It also folds interrupt requests from the SCSI core into a pending flag and drives a single gated interrupt output.

Software writes to the control word are filtered before they are stored. The top nibble always holds a fixed version code. A value with bit 7 set fires a one-cycle reset pulse toward the SCSI core. Bit 6 clears itself on most writes. A write of all zeros becomes 0x40. When the core reports that it has moved bytes, the address pointer advances by that byte count. Bus reads have zero wait states.

Top module: `scsi_dma_csr`

## Requirements
- R1: After reset the control word reads 0xA000_0000, the other three registers read zero, and `irq_out` and `core_rst` are low.
- R2: Bits [3:2] of `bus_addr` select the register (0 control, 1 DMA address, 2 and 3 general purpose) and bits [1:0] are ignored. Registers 2 and 3 store and return all 32 written bits, and a read returns data in the same cycle.
- R3: Bits [31:28] of the control word always read 0xA, whatever value was written.
- R4: A control write with bit 7 set drives `core_rst` high for exactly the one cycle after the write edge. The value stored still has bit 7 set.
- R5: A control write with bit 7 clear and bit 6 set is stored with bit 6 cleared.
- R6: A control write of 0x0000_0000 stores 0x40, so the control word reads 0xA000_0040.
- R7: Control bit 0 (interrupt pending) is set by `core_irq_req` and cleared by `core_irq_ack`. If both arrive in the same cycle, the set wins. A request also overrides a bus write in that cycle.
- R8: `irq_out` is registered and equals control bit 0 AND control bit 4 (enable), as held one cycle earlier. A control write with bit 4 clear therefore drops `irq_out` one cycle after the write.
- R9: A bus write to the DMA address register sets control bit 26 (address loaded).
- R10: A pulse on `adv_valid` adds the zero-extended `adv_len` to the DMA address at that clock edge. A bus write to the address register in the same cycle takes priority.
- R11: `dir_to_mem` equals control bit 8 (1 means data moves from the device to memory).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address in the window; bits [3:2] pick the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the register state |
| core_irq_req | input | 1 | Interrupt request from the SCSI core |
| core_irq_ack | input | 1 | SCSI core reports that its interrupt register was read |
| adv_valid | input | 1 | Core moved `adv_len` bytes this cycle |
| adv_len | input | 16 | Byte count for the address advance |
| core_rst | output | 1 | One-cycle reset pulse to the SCSI core |
| dir_to_mem | output | 1 | Transfer direction (control bit 8) |
| irq_out | output | 1 | Gated, registered interrupt |

## Verification
The properties assume that `bus_sel`, `bus_wr`, the request and acknowledge lines and `adv_valid` are known 0/1 values at every clock edge. They also assume that `adv_len` only matters while `adv_valid` is high. The stimulus changes inputs only on the falling edge and returns every strobe to zero after one cycle. It keeps `adv_len` small so that the address sum never wraps. Only one test step drives a request and an acknowledge together, and it does so on purpose to check the priority rule.

// File: rtl/scsi_dma_csr_pkg.sv
package scsi_dma_csr_pkg;

    localparam int DATA_W   = 32;
    localparam int REG_CNT  = 4;
    localparam int IDX_W    = $clog2(REG_CNT);
    localparam int WIN_W    = IDX_W + 2;

    localparam logic [3:0] VERSION_CODE = 4'hA;

    localparam int B_PEND   = 0;
    localparam int B_IEN    = 4;
    localparam int B_SCLR   = 6;
    localparam int B_CRST   = 7;
    localparam int B_DIR    = 8;
    localparam int B_LOADED = 26;

    localparam logic [DATA_W-1:0] ZERO_SUBST = 32'h0000_0040;

    typedef enum logic [IDX_W-1:0] {
        REG_CTRL  = 2'd0,
        REG_ADDR  = 2'd1,
        REG_GP0   = 2'd2,
        REG_GP1   = 2'd3
    } reg_idx_e;

    typedef struct packed {
        logic              wr;
        reg_idx_e          idx;
        logic [DATA_W-1:0] data;
    } bus_op_t;

    function automatic logic [DATA_W-1:0] ctrl_filter(input logic [DATA_W-1:0] w);
        logic [DATA_W-1:0] v;
        v = w;
        if (!w[B_CRST] && w[B_SCLR])
            v[B_SCLR] = 1'b0;
        else if (w == '0)
            v = ZERO_SUBST;
        v[DATA_W-1 -: 4] = VERSION_CODE;
        return v;
    endfunction

endpackage

// File: rtl/csr_ctrl_reg.sv
module csr_ctrl_reg
    import scsi_dma_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              irq_req,
    input  logic              irq_ack,
    input  logic              loaded_set,
    output logic [DATA_W-1:0] ctrl_q,
    output logic              rst_pulse
);

    localparam logic [DATA_W-1:0] CTRL_RST = {VERSION_CODE, {(DATA_W-4){1'b0}}};

    logic [DATA_W-1:0] ctrl_d;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en)
            ctrl_d = ctrl_filter(wdata);
        if (loaded_set)
            ctrl_d[B_LOADED] = 1'b1;
        if (irq_ack)
            ctrl_d[B_PEND] = 1'b0;
        if (irq_req)
            ctrl_d[B_PEND] = 1'b1;
        ctrl_d[DATA_W-1 -: 4] = VERSION_CODE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= CTRL_RST;
            rst_pulse <= 1'b0;
        end else begin
            ctrl_q    <= ctrl_d;
            rst_pulse <= wr_en && wdata[B_CRST];
        end
    end

endmodule

// File: rtl/csr_addr_reg.sv
module csr_addr_reg
    import scsi_dma_csr_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              adv_valid,
    input  logic [LEN_W-1:0]  adv_len,
    output logic [DATA_W-1:0] addr_q
);

    localparam int PAD_W = DATA_W - LEN_W;

    logic [DATA_W-1:0] len_ext;
    assign len_ext = {{PAD_W{1'b0}}, adv_len};

    always_ff @(posedge clk) begin
        if (rst)
            addr_q <= '0;
        else if (wr_en)
            addr_q <= wdata;
        else if (adv_valid)
            addr_q <= addr_q + len_ext;
    end

endmodule

// File: rtl/csr_irq_gen.sv
module csr_irq_gen
    import scsi_dma_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] ctrl_q,
    output logic              irq_out
);

    always_ff @(posedge clk) begin
        if (rst)
            irq_out <= 1'b0;
        else
            irq_out <= ctrl_q[B_PEND] && ctrl_q[B_IEN];
    end

endmodule

// File: rtl/scsi_dma_csr.sv
module scsi_dma_csr
    import scsi_dma_csr_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [WIN_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              core_irq_req,
    input  logic              core_irq_ack,
    input  logic              adv_valid,
    input  logic [LEN_W-1:0]  adv_len,
    output logic              core_rst,
    output logic              dir_to_mem,
    output logic              irq_out
);

    bus_op_t           op;
    logic [REG_CNT-1:0] wr_hit;
    logic [DATA_W-1:0] rd_bank [REG_CNT];
    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] addr_q;

    always_comb begin
        op.wr   = bus_sel && bus_wr;
        op.idx  = reg_idx_e'(bus_addr[WIN_W-1:2]);
        op.data = bus_wdata;
    end

    genvar gi;
    generate
        for (gi = 0; gi < REG_CNT; gi++) begin : g_dec
            assign wr_hit[gi] = op.wr && (op.idx == reg_idx_e'(gi));
        end
    endgenerate

    csr_ctrl_reg u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_hit[REG_CTRL]),
        .wdata      (op.data),
        .irq_req    (core_irq_req),
        .irq_ack    (core_irq_ack),
        .loaded_set (wr_hit[REG_ADDR]),
        .ctrl_q     (ctrl_q),
        .rst_pulse  (core_rst)
    );

    csr_addr_reg #(.LEN_W(LEN_W)) u_addr (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_hit[REG_ADDR]),
        .wdata     (op.data),
        .adv_valid (adv_valid),
        .adv_len   (adv_len),
        .addr_q    (addr_q)
    );

    csr_irq_gen u_irq (
        .clk     (clk),
        .rst     (rst),
        .ctrl_q  (ctrl_q),
        .irq_out (irq_out)
    );

    assign rd_bank[REG_CTRL] = ctrl_q;
    assign rd_bank[REG_ADDR] = addr_q;

    generate
        for (gi = int'(REG_GP0); gi < REG_CNT; gi++) begin : g_gp
            logic [DATA_W-1:0] gp_q;
            always_ff @(posedge clk) begin
                if (rst)
                    gp_q <= '0;
                else if (wr_hit[gi])
                    gp_q <= op.data;
            end
            assign rd_bank[gi] = gp_q;
        end
    endgenerate

    assign bus_rdata  = rd_bank[op.idx];
    assign dir_to_mem = ctrl_q[B_DIR];

endmodule

// File: rtl/scsi_dma_csr_chk.sv
module scsi_dma_csr_chk
    import scsi_dma_csr_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [WIN_W-1:0]  bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              core_irq_req,
    input logic              adv_valid,
    input logic [LEN_W-1:0]  adv_len,
    input logic              core_rst,
    input logic              irq_out,
    input logic [DATA_W-1:0] ctrl_q,
    input logic [DATA_W-1:0] addr_q
);

    logic ctrl_wr, addr_wr;
    assign ctrl_wr = bus_sel && bus_wr && (bus_addr[WIN_W-1:2] == 2'd0);
    assign addr_wr = bus_sel && bus_wr && (bus_addr[WIN_W-1:2] == 2'd1);

    assert_version_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_addr[WIN_W-1:2] == 2'd0) |-> (bus_rdata[31:28] == VERSION_CODE));

    assert_rst_fire_R4: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && bus_wdata[B_CRST]) |=> core_rst);

    assert_rst_cause_R4: assert property (@(posedge clk) disable iff (rst)
        core_rst |-> $past(ctrl_wr && bus_wdata[B_CRST]));

    assert_pend_set_R7: assert property (@(posedge clk) disable iff (rst)
        core_irq_req |=> ctrl_q[B_PEND]);

    assert_irq_gate_R8: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q[B_IEN] |=> !irq_out);

    assert_irq_rise_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_out) |-> $past(ctrl_q[B_PEND]));

    assert_loaded_R9: assert property (@(posedge clk) disable iff (rst)
        addr_wr |=> ctrl_q[B_LOADED]);

    assert_advance_R10: assert property (@(posedge clk) disable iff (rst)
        (adv_valid && !addr_wr) |=> (addr_q == $past(addr_q) + 32'($past(adv_len))));

    assert_addr_wr_R10: assert property (@(posedge clk) disable iff (rst)
        addr_wr |=> (addr_q == $past(bus_wdata)));

endmodule

bind scsi_dma_csr scsi_dma_csr_chk #(.LEN_W(LEN_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .bus_sel      (bus_sel),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .core_irq_req (core_irq_req),
    .adv_valid    (adv_valid),
    .adv_len      (adv_len),
    .core_rst     (core_rst),
    .irq_out      (irq_out),
    .ctrl_q       (ctrl_q),
    .addr_q       (addr_q)
);

// File: tb/sim_scsi_dma_csr.sv
`timescale 1ns/1ps
module sim_scsi_dma_csr;

    typedef enum int {K_RDATA, K_IRQ, K_CRST, K_DIR} kind_e;
    typedef struct {
        kind_e       kind;
        logic [31:0] exp;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        core_irq_req = 1'b0, core_irq_ack = 1'b0;
    logic        adv_valid = 1'b0;
    logic [15:0] adv_len = '0;
    logic        core_rst, dir_to_mem, irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    item_t sb[$];
    event sample_ev;

    always #5 clk = ~clk;

    scsi_dma_csr u0 (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .core_irq_req(core_irq_req), .core_irq_ack(core_irq_ack),
        .adv_valid(adv_valid), .adv_len(adv_len),
        .core_rst(core_rst), .dir_to_mem(dir_to_mem), .irq_out(irq_out)
    );

    // monitor: pops expected items and compares against live outputs
    initial begin
        forever begin
            @(sample_ev);
            while (sb.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = sb.pop_front();
                case (it.kind)
                    K_RDATA: act = bus_rdata;
                    K_IRQ:   act = {31'd0, irq_out};
                    K_CRST:  act = {31'd0, core_rst};
                    default: act = {31'd0, dir_to_mem};
                endcase
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic push(kind_e k, logic [31:0] e, string tag);
        item_t it;
        it.kind = k; it.exp = e; it.tag = tag;
        sb.push_back(it);
        -> sample_ev;
        #1;
    endtask

    task automatic bus_write(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic expect_read(logic [3:0] a, logic [31:0] e, string tag);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        push(K_RDATA, e, tag);
    endtask

    task automatic idle();
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic pulse_irq(logic req, logic ack);
        @(negedge clk);
        core_irq_req = req; core_irq_ack = ack;
        @(negedge clk);
        core_irq_req = 1'b0; core_irq_ack = 1'b0;
    endtask

    task automatic pulse_adv(logic [15:0] n);
        @(negedge clk);
        adv_valid = 1'b1; adv_len = n;
        @(negedge clk);
        adv_valid = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        #1;
        push(K_IRQ,  32'd0, "R1 irq_out after reset");
        push(K_CRST, 32'd0, "R1 core_rst after reset");
        expect_read(4'h0, 32'hA000_0000, "R1 control reset");
        expect_read(4'h4, 32'h0, "R1 address reset");
        expect_read(4'h8, 32'h0, "R1 gp0 reset");
        expect_read(4'hC, 32'h0, "R1 gp1 reset");

        // R2 register select, low address bits ignored
        bus_write(4'h9, 32'hDEAD_BEEF);
        bus_write(4'hF, 32'h1234_5678);
        expect_read(4'h8, 32'hDEAD_BEEF, "R2 gp0 via offset 9");
        expect_read(4'hE, 32'h1234_5678, "R2 gp1 via offset E");

        // R3 version nibble forced; enable and pending both set
        bus_write(4'h0, 32'hFFFF_FF3F);
        expect_read(4'h0, 32'hAFFF_FF3F, "R3 version nibble");
        push(K_IRQ, 32'd1, "R8 irq asserted by written pend+enable");

        // R8 write with enable clear drops irq; R11 direction bit
        bus_write(4'h0, 32'h0000_0101);
        push(K_IRQ, 32'd1, "R8 irq still old value in write cycle+0");
        expect_read(4'h0, 32'hA000_0101, "R11 control with dir");
        push(K_IRQ, 32'd0, "R8 irq dropped after enable cleared");
        push(K_DIR, 32'd1, "R11 dir_to_mem set");

        // R5 bit 6 self-clear
        bus_write(4'h0, 32'h0000_0050);
        push(K_CRST, 32'd0, "R4 no pulse without bit7");
        expect_read(4'h0, 32'hA000_0010, "R5 bit6 cleared");
        push(K_DIR, 32'd0, "R11 dir_to_mem clear");

        // R6 zero substitution
        bus_write(4'h0, 32'h0000_0000);
        expect_read(4'h0, 32'hA000_0040, "R6 zero write stored as 0x40");

        // R4 reset pulse
        bus_write(4'h0, 32'h0000_00C0);
        push(K_CRST, 32'd1, "R4 pulse after bit7 write");
        idle();
        #1;
        push(K_CRST, 32'd0, "R4 pulse lasts one cycle");
        expect_read(4'h0, 32'hA000_00C0, "R4 bit7 and bit6 kept");

        // R7 pending set / clear, R8 irq follows
        bus_write(4'h0, 32'h0000_0010);
        pulse_irq(1'b1, 1'b0);
        expect_read(4'h0, 32'hA000_0011, "R7 pending set by request");
        push(K_IRQ, 32'd1, "R8 irq from pending and enable");
        pulse_irq(1'b0, 1'b1);
        expect_read(4'h0, 32'hA000_0010, "R7 pending cleared by ack");
        push(K_IRQ, 32'd0, "R8 irq released after ack");
        pulse_irq(1'b1, 1'b1);
        expect_read(4'h0, 32'hA000_0011, "R7 request wins over ack");

        // R9 loaded flag, R10 address advance
        bus_write(4'h4, 32'h0000_1000);
        expect_read(4'h0, 32'hA400_0011, "R9 loaded flag set");
        expect_read(4'h4, 32'h0000_1000, "R10 address written");
        pulse_adv(16'h0020);
        expect_read(4'h4, 32'h0000_1020, "R10 advance by 0x20");
        pulse_adv(16'hFFFF);
        expect_read(4'h4, 32'h0001_101F, "R10 advance by 0xFFFF");
        @(negedge clk);
        adv_valid = 1'b1; adv_len = 16'h0008;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'h4; bus_wdata = 32'h0000_2000;
        @(negedge clk);
        adv_valid = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
        expect_read(4'h4, 32'h0000_2000, "R10 bus write beats advance");

        idle();
        #1;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule